// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes programming frames from a slow serial clock and data pair and turns each complete frame into one of three actions: a write of a 12-bit value into the operating-mode register, a write into the limit register, or a one-cycle OFF command that returns the receiver to polling. A frame holds 15 bits. The first two bits choose the action, the next twelve carry the payload most significant bit first, and the last is a stop bit that must be 0 for the frame to count. The serial clock and data are resynchronised into the system clock domain, and a bit is taken on each rising edge of the serial clock. The frame-enable input marks the span of a frame: lowering it ends or aborts the frame.

Both registers load default values at power-on reset, so the receiver works without any programming. A strobe from an external brown-out detector raises a reset marker, as does power-on reset. The marker stays high until both registers have been written again by valid frames.

The frame state machine has four states. IDLE waits for frame enable. SHIFT takes bits and counts them. DECODE lasts one cycle and issues the action. DONE waits for frame enable to drop. The transitions are as follows. IDLE→SHIFT happens when enable goes high. SHIFT→DECODE happens on the 15th sampled bit. DECODE→DONE always follows. Any state returns to IDLE when enable is low.

Top module: `cfg_loader_top`

## Requirements
- R1: After reset the operating-mode register holds MODE_DEFAULT (0x5A3), the limit register holds LIMIT_DEFAULT (0x0C7), off_pulse is 0 and reset_marker is 1.
- R2: A frame is 15 bits, each sampled on a rising edge of ser_clk while frm_en is high. Bit 1 comes first, then bit 2, then payload bits 3 to 14 (MSB first), then stop bit 15.
- R3: A valid frame with bit 1 = 1 produces exactly one off_pulse and leaves both registers unchanged, whatever the value of bit 2.
- R4: A valid frame with bit 1 = 0 and bit 2 = 1 loads the payload into mode_reg and leaves limit_reg unchanged.
- R5: A valid frame with bit 1 = 0 and bit 2 = 0 loads the payload into limit_reg and leaves mode_reg unchanged.
- R6: A frame whose stop bit (bit 15) is 1 is discarded. No register changes and no off_pulse is produced.
- R7: If frm_en drops before 15 bits have been sampled, the partial frame has no effect, and the next frame starts again from bit 1.
- R8: Bits clocked after the 15th bit while frm_en stays high are ignored.
- R9: A one-cycle brownout strobe sets reset_marker on the next cycle and leaves the register contents untouched.
- R10: reset_marker clears only once both registers have been written by valid frames since it was last set. A write to only one register keeps it high.
- R11: Each frame produces at most one action, and off_pulse is high for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| frm_en | input | 1 | High for the duration of a programming frame |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, stable around rising ser_clk |
| brownout | input | 1 | One-cycle strobe from the supply monitor |
| mode_reg | output | 12 | Operating-mode register value |
| limit_reg | output | 12 | Limit register value |
| off_pulse | output | 1 | One-cycle OFF command |
| reset_marker | output | 1 | High while reprogramming is required |

## Verification
A wrong bit count or a shift-register slip shows up as a misplaced or rotated payload in a register, or as the wrong action, within about three system cycles after the 15th ser_clk edge. A state machine stuck in SHIFT or DONE shows up at the next frame, which then writes nothing or acts on stale bits. A marker that tracks writes wrongly shows up as reset_marker clearing after a single register write, or never clearing. The bench checks all outputs after every frame, so any such fault is reported at the frame that exposes it.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_DECODE = 2'd2,
        ST_DONE   = 2'd3
    } frm_state_t;

    function automatic int frame_len(input int data_w);
        return data_w + 3;
    endfunction

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic bit_stb,
    output logic bit_val
);
    logic [STAGES-1:0] clk_sync;
    logic [STAGES-1:0] dat_sync;
    logic              clk_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sync <= '0;
                    dat_sync <= '0;
                end else begin
                    clk_sync <= ser_clk;
                    dat_sync <= ser_dat;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_sync <= '0;
                    dat_sync <= '0;
                end else begin
                    clk_sync <= {clk_sync[STAGES-2:0], ser_clk};
                    dat_sync <= {dat_sync[STAGES-2:0], ser_dat};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_last <= 1'b0;
        else        clk_last <= clk_sync[STAGES-1];
    end

    assign bit_stb = clk_sync[STAGES-1] & ~clk_last;
    assign bit_val = dat_sync[STAGES-1];

    // R2: a strobe is a single-cycle event
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_en,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              wr_mode,
    output logic              wr_limit,
    output logic              off_cmd,
    output logic [DATA_W-1:0] payload
);
    localparam int FRAME_BITS = frame_len(DATA_W);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int LAST_IDX   = FRAME_BITS - 1;

    frm_state_t state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shreg_q;

    logic sel_off, sel_mode, stop_bit;
    assign sel_off  = shreg_q[FRAME_BITS-1];
    assign sel_mode = shreg_q[FRAME_BITS-2];
    assign stop_bit = shreg_q[0];
    assign payload  = shreg_q[FRAME_BITS-3:1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frm_en) state_d = ST_SHIFT;
            ST_SHIFT:  if (!frm_en) state_d = ST_IDLE;
                       else if (bit_stb && cnt_q == CNT_W'(LAST_IDX)) state_d = ST_DECODE;
            ST_DECODE: state_d = frm_en ? ST_DONE : ST_IDLE;
            ST_DONE:   if (!frm_en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (state_q == ST_SHIFT && frm_en && bit_stb) begin
            shreg_q <= {shreg_q[FRAME_BITS-2:0], bit_val};
            cnt_q   <= (cnt_q == CNT_W'(LAST_IDX)) ? '0 : cnt_q + 1'b1;
        end else if (state_q == ST_IDLE) begin
            cnt_q   <= '0;
        end
    end

    // action outputs
    always_comb begin
        wr_mode  = 1'b0;
        wr_limit = 1'b0;
        off_cmd  = 1'b0;
        unique case (state_q)
            ST_DECODE: begin
                if (!stop_bit) begin
                    if (sel_off)       off_cmd  = 1'b1;
                    else if (sel_mode) wr_mode  = 1'b1;
                    else               wr_limit = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // R11: one action at most per decode
    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_mode, wr_limit, off_cmd}));
    // R2: counter never passes the last bit index
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LAST_IDX));
    // R8: after a decode, no second decode without leaving the frame
    a_r8_no_redecode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (state_q != ST_DECODE));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int               DATA_W        = 12,
    parameter logic [DATA_W-1:0] MODE_DEFAULT  = 12'h5A3,
    parameter logic [DATA_W-1:0] LIMIT_DEFAULT = 12'h0C7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_limit,
    input  logic              off_cmd,
    input  logic              brownout,
    input  logic [DATA_W-1:0] payload,
    output logic [DATA_W-1:0] mode_reg,
    output logic [DATA_W-1:0] limit_reg,
    output logic              off_pulse,
    output logic              reset_marker
);
    logic mode_ok_q, limit_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_reg  <= MODE_DEFAULT;
            limit_reg <= LIMIT_DEFAULT;
            off_pulse <= 1'b0;
        end else begin
            if (wr_mode)  mode_reg  <= payload;
            if (wr_limit) limit_reg <= payload;
            off_pulse <= off_cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_ok_q  <= 1'b0;
            limit_ok_q <= 1'b0;
        end else if (brownout) begin
            mode_ok_q  <= 1'b0;
            limit_ok_q <= 1'b0;
        end else begin
            if (wr_mode)  mode_ok_q  <= 1'b1;
            if (wr_limit) limit_ok_q <= 1'b1;
        end
    end

    assign reset_marker = ~(mode_ok_q & limit_ok_q);

    // R11: OFF pulse is one cycle wide
    a_r11_off_single: assert property (@(posedge clk) disable iff (!rst_n)
        off_pulse |=> !off_pulse);
    // R9: brown-out raises the marker on the next cycle
    a_r9_bo_marker: assert property (@(posedge clk) disable iff (!rst_n)
        brownout |=> reset_marker);
    // R9: brown-out alone keeps register contents
    a_r9_bo_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout && !wr_mode && !wr_limit) |=> ($stable(mode_reg) && $stable(limit_reg)));
    // R4: mode register only moves on a mode write
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_reg));
    // R5: limit register only moves on a limit write
    a_r5_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_limit |=> $stable(limit_reg));
    // R10: marker only clears after a register write
    a_r10_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_marker) |-> $past(wr_mode || wr_limit));
endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top #(
    parameter int                DATA_W        = 12,
    parameter int                SYNC_STAGES   = 2,
    parameter logic [DATA_W-1:0] MODE_DEFAULT  = 12'h5A3,
    parameter logic [DATA_W-1:0] LIMIT_DEFAULT = 12'h0C7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              brownout,
    output logic [DATA_W-1:0] mode_reg,
    output logic [DATA_W-1:0] limit_reg,
    output logic              off_pulse,
    output logic              reset_marker
);
    logic              bit_stb, bit_val;
    logic              wr_mode, wr_limit, off_cmd;
    logic [DATA_W-1:0] payload;

    cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    cfg_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_en   (frm_en),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .wr_mode  (wr_mode),
        .wr_limit (wr_limit),
        .off_cmd  (off_cmd),
        .payload  (payload)
    );

    cfg_reg_bank #(
        .DATA_W        (DATA_W),
        .MODE_DEFAULT  (MODE_DEFAULT),
        .LIMIT_DEFAULT (LIMIT_DEFAULT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_mode      (wr_mode),
        .wr_limit     (wr_limit),
        .off_cmd      (off_cmd),
        .brownout     (brownout),
        .payload      (payload),
        .mode_reg     (mode_reg),
        .limit_reg    (limit_reg),
        .off_pulse    (off_pulse),
        .reset_marker (reset_marker)
    );
endmodule

// File: tb/test_cfg_loader_top.sv
`timescale 1ns/1ps
module test_cfg_loader_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_en = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        brownout = 1'b0;
    logic [11:0] mode_reg, limit_reg;
    logic        off_pulse, reset_marker;

    int checks = 0;
    int errors = 0;
    int off_seen = 0;
    bit finished = 0;

    logic [11:0] exp_mode, exp_limit;
    int          exp_off;
    bit          ok_mode, ok_limit;

    always #4 clk = ~clk;

    cfg_loader_top i_cfg_loader_top (
        .clk(clk), .rst_n(rst_n), .frm_en(frm_en), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .brownout(brownout), .mode_reg(mode_reg),
        .limit_reg(limit_reg), .off_pulse(off_pulse), .reset_marker(reset_marker)
    );

    always @(posedge clk) if (rst_n && off_pulse) off_seen++;

    function automatic logic [14:0] mk(input bit b1, input bit b2,
                                       input logic [11:0] pl, input bit stop);
        return {b1, b2, pl, stop};
    endfunction

    function automatic bit exp_marker();
        return !(ok_mode && ok_limit);
    endfunction

    task automatic model(input logic [14:0] f);
        if (!f[0]) begin
            if (f[14])      exp_off++;
            else if (f[13]) begin exp_mode  = f[12:1]; ok_mode  = 1; end
            else            begin exp_limit = f[12:1]; ok_limit = 1; end
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [14:0] f, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); ser_dat = f[14 - (i % 15)];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic frame(input logic [14:0] f, input int nbits);
        @(negedge clk); frm_en = 1'b1;
        repeat (2) @(negedge clk);
        send_bits(f, nbits);
        repeat (6) @(negedge clk);
        frm_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " mode_reg"},  32'(mode_reg),  32'(exp_mode));
        chk({tag, " limit_reg"}, 32'(limit_reg), 32'(exp_limit));
        chk({tag, " off count"}, 32'(off_seen),  32'(exp_off));
        chk({tag, " marker"},    32'(reset_marker), 32'(exp_marker()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] f;
        void'($urandom(32'd7781));
        exp_mode = 12'h5A3; exp_limit = 12'h0C7; exp_off = 0;
        ok_mode = 0; ok_limit = 0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 mode default",  32'(mode_reg),  32'h5A3);
        chk("R1 limit default", 32'(limit_reg), 32'h0C7);
        chk("R1 off low",       32'(off_pulse), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 marker set", 32'(reset_marker), 1);

        // R4 / R2 mode write, asymmetric payload reveals bit order
        f = mk(0, 1, 12'h8E1, 0); frame(f, 15); model(f); check_all("R4 R2");
        // R10 one register written: marker stays
        chk("R10 marker after one write", 32'(reset_marker), 1);
        // R5 limit write
        f = mk(0, 0, 12'h13C, 0); frame(f, 15); model(f); check_all("R5");
        chk("R10 marker cleared", 32'(reset_marker), 0);
        // R3 OFF, bit2 = 1 and bit2 = 0
        f = mk(1, 1, 12'hFFF, 0); frame(f, 15); model(f); check_all("R3 b2=1");
        f = mk(1, 0, 12'h000, 0); frame(f, 15); model(f); check_all("R3 b2=0");
        // R6 stop bit set: discarded (mode, limit, off)
        f = mk(0, 1, 12'h777, 1); frame(f, 15); model(f); check_all("R6 mode");
        f = mk(0, 0, 12'h666, 1); frame(f, 15); model(f); check_all("R6 limit");
        f = mk(1, 0, 12'h555, 1); frame(f, 15); model(f); check_all("R6 off");
        // R7 aborted partial frame then full frame
        frame(mk(0, 1, 12'hABC, 0), 10); check_all("R7 abort");
        f = mk(0, 0, 12'h2D4, 0); frame(f, 15); model(f); check_all("R7 restart");
        // R8 extra bits after the 15th ignored
        f = mk(0, 1, 12'h0F0, 0); frame(f, 22); model(f); check_all("R8");
        // R9 brownout: marker up, contents kept
        @(negedge clk); brownout = 1'b1; @(negedge clk); brownout = 1'b0;
        ok_mode = 0; ok_limit = 0;
        @(negedge clk);
        check_all("R9");
        f = mk(0, 0, 12'h9A9, 0); frame(f, 15); model(f); check_all("R10 one of two");
        f = mk(0, 1, 12'h3B3, 0); frame(f, 15); model(f); check_all("R10 both");

        // R11 random frames, single action and single-cycle pulse
        for (int n = 0; n < 40; n++) begin
            f = 15'($urandom);
            f[0] = (($urandom % 4) == 0);
            frame(f, 15); model(f);
            check_all("R11 random");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule